// File: doc/BRIEF.md
# Mixed Latched/Level Interrupt Aggregator

This block gathers 32 interrupt request lines into one registered host interrupt output. Three requests come from the host bus interface itself (bus underrun, bus overrun and bus error). The other 29 come from surrounding functional blocks. Software reaches the block through a small synchronous register port with address, write strobe, write data and registered read data. The port exposes three words: a flag word, an enable word and a masked status word.

The flag word has two kinds of bits. The lower sixteen bits capture any request that goes high and keep it until software writes a one to that bit. The upper sixteen bits hold no state. They show the live level of their request lines, because those sources keep their own latch and are cleared at the source. If a request and a clear of the same lower bit arrive in the same cycle, the request wins. The status word is the flag word gated by the enable word. The host interrupt goes high one cycle after any status bit becomes one.

Top module: `irq_aggregator`

## Requirements
- R1: During and right after synchronous reset, the flag and enable words read 0, the status word reads 0, `host_irq` is 0 and `reg_rdata` is 0.
- R2: A request on any of bits 15..0 that is high at a clock edge sets that flag bit. The bit stays at 1 after the request drops.
- R3: Writing the flag word (byte offset 0x0) clears each of bits 15..0 whose write-data bit is 1. Write-data bits that are 0 leave their flags unchanged.
- R4: If a request on bits 15..0 is high at the same edge where a write of 1 to the flag word tries to clear that bit, the flag stays at 1.
- R5: Flag bits 31..16 always read the current level of their request lines. They are never held, and writes to them have no effect.
- R6: The enable word at byte offset 0x4 is read/write, with one mask bit per interrupt.
- R7: The status word at byte offset 0x8 reads as flag AND enable. Writes to it change neither the flag word nor the enable word.
- R8: `host_irq` is the OR of all status bits, registered. It changes one clock edge after the flag, enable or request state that causes the change.
- R9: Bus underrun, bus overrun and bus error drive flag bits 0, 1 and 2. Line k of `src_req` drives flag bit k+3.
- R10: Read data appears one cycle after the address is presented. Any other offset reads 0, and reads do not change any state.
- R11: A lower-group request that stays high keeps its flag at 1 through a clear write. The flag can only be cleared once the request has dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| bus_underrun | input | 1 | Host bus underrun event (flag bit 0) |
| bus_overrun | input | 1 | Host bus overrun event (flag bit 1) |
| bus_error | input | 1 | Host bus error event (flag bit 2) |
| src_req | input | 29 | Requests from other blocks, line k drives flag bit k+3 |
| reg_addr | input | 4 | Register byte offset |
| reg_wr | input | 1 | Write strobe for the addressed register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data for the previous cycle's address |
| host_irq | output | 1 | Registered OR of the masked status |

## Verification
Two events can land on the same edge: a lower-group request setting a flag, and a write-one-to-clear aimed at that same flag. The bench provokes this in two ways. It drives a request pulse in the same cycle as a clear write of its bit. It also holds a request high across a clear write. In both cases a later read of the flag word must still show the bit at 1. A clear issued after the request has dropped must then remove it. Checker properties watch every lower bit: whenever a request is high, the flag must be 1 on the next edge, whether or not a clear is present.

// File: rtl/irq_pkg.sv
package irq_pkg;

    localparam int IRQ_N     = 32;
    localparam int LATCH_N   = 16;
    localparam int HOSTSRC_N = 3;
    localparam int EXT_N     = IRQ_N - HOSTSRC_N;
    localparam int ADDR_W    = 4;
    localparam int DATA_W    = 32;

    localparam logic [ADDR_W-1:0] OFS_FLAG = 4'h0;
    localparam logic [ADDR_W-1:0] OFS_MASK = 4'h4;
    localparam logic [ADDR_W-1:0] OFS_STAT = 4'h8;

    typedef enum logic [1:0] {
        SEL_FLAG = 2'd0,
        SEL_MASK = 2'd1,
        SEL_STAT = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic              wr;
        reg_sel_e          sel;
        logic [DATA_W-1:0] wdata;
    } bus_cmd_t;

    function automatic reg_sel_e decode_sel(input logic [ADDR_W-1:0] a);
        reg_sel_e s;
        if (a == OFS_FLAG)      s = SEL_FLAG;
        else if (a == OFS_MASK) s = SEL_MASK;
        else if (a == OFS_STAT) s = SEL_STAT;
        else                    s = SEL_NONE;
        return s;
    endfunction

endpackage

// File: rtl/irq_bus_decode.sv
module irq_bus_decode
    import irq_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    output bus_cmd_t          cmd
);
    always_comb begin
        cmd.wr    = wr;
        cmd.sel   = decode_sel(addr);
        cmd.wdata = wdata;
    end
endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank
    import irq_pkg::*;
#(
    parameter int N  = IRQ_N,
    parameter int LN = LATCH_N
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [N-1:0]  req,
    input  logic          clr_en,
    input  logic [LN-1:0] clr_mask,
    output logic [N-1:0]  flag
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        if (i < LN) begin : g_held
            logic held_q;
            always_ff @(posedge clk) begin
                if (rst)
                    held_q <= 1'b0;
                else
                    held_q <= req[i] | (held_q & ~(clr_en & clr_mask[i]));
            end
            assign flag[i] = held_q;
        end else begin : g_live
            assign flag[i] = req[i];
        end
    end
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg
    import irq_pkg::*;
#(
    parameter int N = IRQ_N
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  logic [N-1:0] wdata,
    output logic [N-1:0] en
);
    always_ff @(posedge clk) begin
        if (rst)
            en <= '0;
        else if (wr_en)
            en <= wdata;
    end
endmodule

// File: rtl/irq_read_port.sv
module irq_read_port
    import irq_pkg::*;
#(
    parameter int N = IRQ_N
) (
    input  logic         clk,
    input  logic         rst,
    input  reg_sel_e     sel,
    input  logic [N-1:0] flag,
    input  logic [N-1:0] en,
    input  logic [N-1:0] stat,
    output logic [N-1:0] rdata
);
    logic [N-1:0] mux_d;

    always_comb begin
        unique case (sel)
            SEL_FLAG: mux_d = flag;
            SEL_MASK: mux_d = en;
            SEL_STAT: mux_d = stat;
            default:  mux_d = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            rdata <= '0;
        else
            rdata <= mux_d;
    end
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
    import irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_underrun,
    input  logic              bus_overrun,
    input  logic              bus_error,
    input  logic [EXT_N-1:0]  src_req,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              host_irq
);
    bus_cmd_t          cmd;
    logic [IRQ_N-1:0]  req_vec;
    logic [IRQ_N-1:0]  flag_vis;
    logic [IRQ_N-1:0]  en_q;
    logic [IRQ_N-1:0]  stat_vis;
    logic              irq_q;

    // host-interface sources occupy the lowest (held) positions
    assign req_vec = {src_req, bus_error, bus_overrun, bus_underrun};

    irq_bus_decode u_dec (
        .addr  (reg_addr),
        .wr    (reg_wr),
        .wdata (reg_wdata),
        .cmd   (cmd)
    );

    irq_flag_bank #(.N(IRQ_N), .LN(LATCH_N)) u_flags (
        .clk      (clk),
        .rst      (rst),
        .req      (req_vec),
        .clr_en   (cmd.wr && cmd.sel == SEL_FLAG),
        .clr_mask (cmd.wdata[LATCH_N-1:0]),
        .flag     (flag_vis)
    );

    irq_mask_reg #(.N(IRQ_N)) u_mask (
        .clk   (clk),
        .rst   (rst),
        .wr_en (cmd.wr && cmd.sel == SEL_MASK),
        .wdata (cmd.wdata),
        .en    (en_q)
    );

    assign stat_vis = flag_vis & en_q;

    irq_read_port #(.N(IRQ_N)) u_rd (
        .clk   (clk),
        .rst   (rst),
        .sel   (cmd.sel),
        .flag  (flag_vis),
        .en    (en_q),
        .stat  (stat_vis),
        .rdata (reg_rdata)
    );

    always_ff @(posedge clk) begin
        if (rst)
            irq_q <= 1'b0;
        else
            irq_q <= |stat_vis;
    end

    assign host_irq = irq_q;
endmodule

// File: rtl/irq_aggregator_chk.sv
module irq_aggregator_chk
    import irq_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [IRQ_N-1:0]  req_vec,
    input logic [IRQ_N-1:0]  flag_vis,
    input logic [IRQ_N-1:0]  en_q,
    input logic              host_irq,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic [DATA_W-1:0] reg_rdata
);
    logic wr_flag, wr_mask, unmapped;
    assign wr_flag  = reg_wr && reg_addr == OFS_FLAG;
    assign wr_mask  = reg_wr && reg_addr == OFS_MASK;
    assign unmapped = reg_addr != OFS_FLAG && reg_addr != OFS_MASK && reg_addr != OFS_STAT;

    p_reset_state_r1: assert property (@(posedge clk)
        rst |=> (en_q == '0 && !host_irq && reg_rdata == '0 && flag_vis[LATCH_N-1:0] == '0));

    for (genvar i = 0; i < LATCH_N; i++) begin : g_held_chk
        p_capture_r2: assert property (@(posedge clk) disable iff (rst)
            req_vec[i] |=> flag_vis[i]);
        p_set_wins_r4: assert property (@(posedge clk) disable iff (rst)
            (req_vec[i] && wr_flag && reg_wdata[i]) |=> flag_vis[i]);
        p_w1c_r3: assert property (@(posedge clk) disable iff (rst)
            (wr_flag && reg_wdata[i] && !req_vec[i]) |=> !flag_vis[i]);
        p_keep_r3: assert property (@(posedge clk) disable iff (rst)
            (flag_vis[i] && !(wr_flag && reg_wdata[i])) |=> flag_vis[i]);
    end

    p_live_read_r5: assert property (@(posedge clk) disable iff (rst)
        (reg_addr == OFS_FLAG) |=> reg_rdata[IRQ_N-1:LATCH_N] == $past(req_vec[IRQ_N-1:LATCH_N]));

    p_mask_write_r6: assert property (@(posedge clk) disable iff (rst)
        wr_mask |=> en_q == $past(reg_wdata));

    p_mask_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !wr_mask |=> $stable(en_q));

    p_irq_reg_r8: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> host_irq == $past(|(flag_vis & en_q)));

    p_unmapped_r10: assert property (@(posedge clk) disable iff (rst)
        unmapped |=> reg_rdata == '0);
endmodule

bind irq_aggregator irq_aggregator_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_vec   (req_vec),
    .flag_vis  (flag_vis),
    .en_q      (en_q),
    .host_irq  (host_irq),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata)
);

// File: tb/irq_aggregator_test.sv
module irq_aggregator_test;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 13;

    typedef struct packed {
        logic [31:0] rq;
        logic        wr;
        logic [3:0]  wa;
        logic [31:0] wd;
        logic [3:0]  ra;
        logic [31:0] ex;
    } vec_t;

    localparam vec_t VECS [NVEC] = '{
        '{32'h0000_0005, 1'b0, 4'h0, 32'h0,          4'h0, 32'h0000_0005}, // R2 R9
        '{32'h0000_0000, 1'b1, 4'h0, 32'h0000_0001,  4'h0, 32'h0000_0004}, // R3
        '{32'h0000_0000, 1'b1, 4'h0, 32'h0000_0000,  4'h0, 32'h0000_0004}, // R3 zero
        '{32'h0000_0004, 1'b1, 4'h0, 32'h0000_0004,  4'h0, 32'h0000_0004}, // R4
        '{32'h0000_0000, 1'b1, 4'h0, 32'h0000_0004,  4'h0, 32'h0000_0000}, // R3
        '{32'h0003_8000, 1'b0, 4'h0, 32'h0,          4'h0, 32'h0003_8000}, // R5
        '{32'h0003_0000, 1'b1, 4'h0, 32'hFFFF_0000,  4'h0, 32'h0003_8000}, // R5 write
        '{32'h0000_0000, 1'b1, 4'h4, 32'h0001_8000,  4'h4, 32'h0001_8000}, // R6
        '{32'h0001_0000, 1'b0, 4'h0, 32'h0,          4'h8, 32'h0001_8000}, // R7
        '{32'h0000_0000, 1'b1, 4'h8, 32'hFFFF_FFFF,  4'h8, 32'h0000_8000}, // R7 ro
        '{32'h0000_0000, 1'b0, 4'h0, 32'h0,          4'h4, 32'h0001_8000}, // R7 en
        '{32'h0000_0000, 1'b0, 4'h0, 32'h0,          4'hC, 32'h0000_0000}, // R10
        '{32'h0000_0008, 1'b1, 4'h0, 32'h0000_8000,  4'h0, 32'h0000_0008}  // R9 ext
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_underrun = 1'b0, bus_overrun = 1'b0, bus_error = 1'b0;
    logic [28:0] src_req = '0;
    logic [3:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        host_irq;

    int tests = 0;
    int fails = 0;

    irq_aggregator uut (
        .clk, .rst, .bus_underrun, .bus_overrun, .bus_error, .src_req,
        .reg_addr, .reg_wr, .reg_wdata, .reg_rdata, .host_irq
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic report();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    // drive at a falling edge, cross one rising edge, return at the next falling edge
    task automatic step(input logic [31:0] rq, input logic w, input logic [3:0] a,
                        input logic [31:0] d);
        bus_underrun = rq[0];
        bus_overrun  = rq[1];
        bus_error    = rq[2];
        src_req      = rq[31:3];
        reg_wr       = w;
        reg_addr     = a;
        reg_wdata    = d;
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog actual=%h expected=%h", 1, 0);
        report();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 irq in reset", {31'd0, host_irq}, 32'h0);
        chk("R1 rdata in reset", reg_rdata, 32'h0);
        rst = 1'b0;
        step(32'h0, 1'b0, 4'h0, 32'h0);
        chk("R1 flag after reset", reg_rdata, 32'h0);
        step(32'h0, 1'b0, 4'h4, 32'h0);
        chk("R1 enable after reset", reg_rdata, 32'h0);
        step(32'h0, 1'b0, 4'h8, 32'h0);
        chk("R1 status after reset", reg_rdata, 32'h0);

        for (int k = 0; k < NVEC; k++) begin
            step(VECS[k].rq, VECS[k].wr, VECS[k].wa, VECS[k].wd);
            step(VECS[k].rq & 32'hFFFF_0000, 1'b0, VECS[k].ra, 32'h0);
            chk($sformatf("vector %0d (R2..R10)", k), reg_rdata, VECS[k].ex);
        end

        // R8: enable bit 3 (flag 3 pending); irq follows one edge later
        step(32'h0, 1'b1, 4'h4, 32'h0000_0008);
        chk("R8 irq not yet", {31'd0, host_irq}, 32'h0);
        step(32'h0, 1'b0, 4'h0, 32'h0);
        chk("R8 irq raised", {31'd0, host_irq}, 32'h1);
        step(32'h0, 1'b1, 4'h0, 32'h0000_0008);
        chk("R8 irq still high after clear edge", {31'd0, host_irq}, 32'h1);
        step(32'h0, 1'b0, 4'h0, 32'h0);
        chk("R8 irq dropped", {31'd0, host_irq}, 32'h0);

        // R5 upper source straight to irq, not held
        step(32'h0, 1'b1, 4'h4, 32'h0001_0000);
        step(32'h0001_0000, 1'b0, 4'h0, 32'h0);
        chk("R5 live source raises irq", {31'd0, host_irq}, 32'h1);
        step(32'h0, 1'b0, 4'h0, 32'h0);
        chk("R5 irq drops with source", {31'd0, host_irq}, 32'h0);
        step(32'h0, 1'b0, 4'h0, 32'h0);
        chk("R5 upper flag not held", reg_rdata, 32'h0);

        // R11 held request survives clear
        step(32'h0000_0008, 1'b1, 4'h0, 32'h0000_0008);
        step(32'h0000_0008, 1'b0, 4'h0, 32'h0);
        chk("R11 held request keeps flag", reg_rdata, 32'h0000_0008);
        step(32'h0, 1'b1, 4'h0, 32'h0000_0008);
        step(32'h0, 1'b0, 4'h0, 32'h0);
        chk("R3 clear after request drops", reg_rdata, 32'h0);

        // R10 repeated reads leave state alone
        step(32'h0000_0001, 1'b0, 4'h0, 32'h0);
        step(32'h0, 1'b0, 4'h0, 32'h0);
        chk("R10 first read", reg_rdata, 32'h0000_0001);
        step(32'h0, 1'b0, 4'h0, 32'h0);
        chk("R10 second read unchanged", reg_rdata, 32'h0000_0001);

        report();
    end
endmodule